// File: doc/BRIEF.md
# Deferred Register Write-Back Buffer

This block holds back register updates that arrive while one execution packet is in flight. It releases them together when the packet closes, so every operation inside the packet reads the values that stood before the packet began. Each producer request becomes one or two queued entries. An entry carries a destination index, a size code, a data word and a keep-mask. Nothing reaches the destination array until a commit strobe arrives. On commit, every pending entry is merged into its destination in arrival order as `(old & mask) | data`. A discard strobe throws away the pending entries and leaves the array as it is.

Four request kinds are supported. A plain write uses a zero mask, so its data replaces the old value. A masked merge keeps the old bits named by the mask. A 32-bit pair write splits into two 16-bit entries. An accumulator write clips its data to 40 bits. The destination array sits inside the block, and one combinational read port returns committed contents only.

Top module: `wbq_writeback`

## Requirements
- R1: After synchronous reset every destination reads 0, `pend_cnt` is 0 and `overflow` is 0.
- R2: An accepted request raises `pend_cnt` by its entry count (1, or 2 for a pair). Until a commit, `rd_data` keeps returning the committed value.
- R3: Size codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. On commit, a merge entry (`push_kind` = 1) leaves its destination equal to `((old & mask) | data)` over the bits the size covers. Data and mask are both cut to that width, and the bits above it read 0.
- R4: A plain write (`push_kind` = 0) uses a mask of zero, so after commit its destination equals the data cut to its size.
- R5: Commit applies entries in arrival order, so when two entries name the same destination the later one decides the result.
- R6: A commit leaves `pend_cnt` at 0 on the following cycle.
- R7: A discard clears `pend_cnt` and changes no destination. When commit and discard are asserted together, the discard wins.
- R8: A pair write (`push_kind` = 2) queues `push_data[31:16]` as a 16-bit entry to `push_dest` and then `push_data[15:0]` as a 16-bit entry to `push_dest + 1`, where the index after the last destination wraps to 0.
- R9: An accumulator write (`push_kind` = 3) queues a 64-bit entry whose data keeps only bits [39:0] of `push_data`.
- R10: At most DEPTH (16) entries can be pending. A request that does not fit entirely is dropped whole, leaves `pend_cnt` unchanged, and sets `overflow`, which stays at 1 until reset.
- R11: A request presented in the same cycle as commit or discard is dropped and does not set `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Request valid |
| push_kind | input | 2 | 0 plain, 1 merge, 2 pair, 3 accumulator |
| push_dest | input | 4 | Destination index |
| push_size | input | 2 | Size code for plain and merge |
| push_data | input | 64 | Request data |
| push_mask | input | 64 | Keep-mask for merge |
| commit | input | 1 | Apply all pending entries |
| discard | input | 1 | Drop all pending entries |
| rd_idx | input | 4 | Read index |
| rd_data | output | 64 | Committed value of `rd_idx` |
| pend_cnt | output | 5 | Number of pending entries |
| overflow | output | 1 | Sticky overflow flag |

## Verification
The properties assume known control inputs once reset has been released. They also assume `rd_idx` stays within the destination count and that a request with no free slot never arrives together with a flush. The read-stability property assumes that a destination can change only on a commit edge that is not also a discard edge. The bench changes every input at the falling clock edge, draws `push_kind`, size and `rd_idx` only from their legal codes, and keeps each random burst at 0 to 18 requests. That bound keeps most bursts below the depth, while some still cross it to exercise the overflow path.

// File: rtl/wbq_pkg.sv
package wbq_pkg;

    localparam int WORD_W = 64;
    localparam int HALF_W = 16;
    localparam int ACC_W  = 40;

    localparam logic [WORD_W-1:0] ACC_KEEP = {{(WORD_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_MERGE = 2'd1,
        K_PAIR  = 2'd2,
        K_ACC   = 2'd3
    } push_kind_e;

    typedef struct packed {
        logic [1:0]        size;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] mask;
    } wb_payload_t;

    function automatic logic [WORD_W-1:0] size_keep(input logic [1:0] sz);
        logic [WORD_W-1:0] k;
        case (sz)
            2'd0:    k = WORD_W'(8'hFF);
            2'd1:    k = WORD_W'(16'hFFFF);
            2'd2:    k = WORD_W'(32'hFFFF_FFFF);
            default: k = '1;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/wbq_former.sv
module wbq_former
    import wbq_pkg::*;
#(
    parameter int NDEST  = 16,
    parameter int DEST_W = 4
) (
    input  logic [1:0]        kind,
    input  logic [DEST_W-1:0] dest,
    input  logic [1:0]        size,
    input  logic [WORD_W-1:0] data,
    input  logic [WORD_W-1:0] mask,
    output logic [DEST_W-1:0] dest0,
    output logic [DEST_W-1:0] dest1,
    output wb_payload_t       pl0,
    output wb_payload_t       pl1,
    output logic [1:0]        need
);
    logic [WORD_W-1:0] keep;
    push_kind_e        k;

    always_comb begin
        k     = push_kind_e'(kind);
        keep  = size_keep(size);
        dest0 = dest;
        dest1 = (dest == DEST_W'(NDEST - 1)) ? '0 : dest + 1'b1;
        pl1   = '{size: 2'd1, data: WORD_W'(data[HALF_W-1:0]), mask: '0};
        case (k)
            K_PLAIN: begin
                need = 2'd1;
                pl0  = '{size: size, data: data & keep, mask: '0};
            end
            K_MERGE: begin
                need = 2'd1;
                pl0  = '{size: size, data: data & keep, mask: mask & keep};
            end
            K_PAIR: begin
                need = 2'd2;
                pl0  = '{size: 2'd1, data: WORD_W'(data[2*HALF_W-1:HALF_W]), mask: '0};
            end
            default: begin
                need = 2'd1;
                pl0  = '{size: 2'd3, data: data & ACC_KEEP, mask: '0};
            end
        endcase
    end

endmodule

// File: rtl/wbq_queue.sv
module wbq_queue
    import wbq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DEST_W = 4,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              flush,
    input  logic [1:0]        need,
    input  logic [DEST_W-1:0] dest0,
    input  logic [DEST_W-1:0] dest1,
    input  wb_payload_t       pl0,
    input  wb_payload_t       pl1,
    output logic [DEST_W-1:0] q_dest [DEPTH],
    output wb_payload_t       q_pl   [DEPTH],
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf
);
    localparam int QIDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              fits;
    logic              take;
    logic [QIDX_W-1:0] slot0;
    logic [QIDX_W-1:0] slot1;

    always_comb begin
        fits  = (int'(cnt) + int'(need)) <= DEPTH;
        take  = push && !flush && fits;
        slot0 = QIDX_W'(cnt);
        slot1 = QIDX_W'(cnt + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (flush) begin
            cnt <= '0;
        end else if (push) begin
            if (fits) cnt <= cnt + CNT_W'(need);
            else      ovf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && take) begin
            q_dest[slot0] <= dest0;
            q_pl[slot0]   <= pl0;
            if (need == 2'd2) begin
                q_dest[slot1] <= dest1;
                q_pl[slot1]   <= pl1;
            end
        end
    end

endmodule

// File: rtl/wbq_regfile.sv
module wbq_regfile
    import wbq_pkg::*;
#(
    parameter int NDEST  = 16,
    parameter int DEPTH  = 16,
    parameter int DEST_W = 4,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              apply,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DEST_W-1:0] q_dest [DEPTH],
    input  wb_payload_t       q_pl   [DEPTH],
    input  logic [DEST_W-1:0] rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] regs [NDEST];
    logic [WORD_W-1:0] nxt  [NDEST];

    always_comb begin
        for (int j = 0; j < NDEST; j++) nxt[j] = regs[j];
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(cnt)) begin
                nxt[q_dest[i]] = ((nxt[q_dest[i]] & q_pl[i].mask) | q_pl[i].data)
                                 & size_keep(q_pl[i].size);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < NDEST; j++) regs[j] <= '0;
        end else if (apply) begin
            for (int j = 0; j < NDEST; j++) regs[j] <= nxt[j];
        end
    end

    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/wbq_writeback.sv
module wbq_writeback
    import wbq_pkg::*;
#(
    parameter int NDEST = 16,
    parameter int DEPTH = 16,
    localparam int DEST_W = $clog2(NDEST),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [1:0]        push_kind,
    input  logic [DEST_W-1:0] push_dest,
    input  logic [1:0]        push_size,
    input  logic [WORD_W-1:0] push_data,
    input  logic [WORD_W-1:0] push_mask,
    input  logic              commit,
    input  logic              discard,
    input  logic [DEST_W-1:0] rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  pend_cnt,
    output logic              overflow
);
    logic [DEST_W-1:0] dest0, dest1;
    wb_payload_t       pl0, pl1;
    logic [1:0]        need;
    logic [DEST_W-1:0] q_dest [DEPTH];
    wb_payload_t       q_pl   [DEPTH];
    logic              flush;
    logic              apply;

    assign flush = commit | discard;
    assign apply = commit & ~discard;

    wbq_former #(.NDEST(NDEST), .DEST_W(DEST_W)) u_former (
        .kind (push_kind),
        .dest (push_dest),
        .size (push_size),
        .data (push_data),
        .mask (push_mask),
        .dest0(dest0),
        .dest1(dest1),
        .pl0  (pl0),
        .pl1  (pl1),
        .need (need)
    );

    wbq_queue #(.DEPTH(DEPTH), .DEST_W(DEST_W), .CNT_W(CNT_W)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .flush (flush),
        .need  (need),
        .dest0 (dest0),
        .dest1 (dest1),
        .pl0   (pl0),
        .pl1   (pl1),
        .q_dest(q_dest),
        .q_pl  (q_pl),
        .cnt   (pend_cnt),
        .ovf   (overflow)
    );

    wbq_regfile #(.NDEST(NDEST), .DEPTH(DEPTH), .DEST_W(DEST_W), .CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .apply  (apply),
        .cnt    (pend_cnt),
        .q_dest (q_dest),
        .q_pl   (q_pl),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/wbq_checker.sv
module wbq_checker #(
    parameter int DEPTH  = 16,
    parameter int DEST_W = 4,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              push,
    input logic [1:0]        push_kind,
    input logic              commit,
    input logic              discard,
    input logic [DEST_W-1:0] rd_idx,
    input logic [63:0]       rd_data,
    input logic [CNT_W-1:0]  pend_cnt,
    input logic              overflow
);
    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(pend_cnt) <= DEPTH);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R10
    ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !commit && !discard && int'(pend_cnt) == DEPTH) |=> overflow);

    // R6
    commit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> pend_cnt == '0);

    // R7
    discard_clear_chk: assert property (@(posedge clk) disable iff (rst)
        discard |=> pend_cnt == '0);

    // R2
    pending_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (!commit || discard) ##1 $stable(rd_idx) |-> $stable(rd_data));

    // R2
    push_count_chk: assert property (@(posedge clk) disable iff (rst)
        (push && push_kind != 2'd2 && !commit && !discard && int'(pend_cnt) < DEPTH)
        |=> pend_cnt == $past(pend_cnt) + 1'b1);

    // R11
    flush_push_chk: assert property (@(posedge clk) disable iff (rst)
        (push && (commit || discard) && !overflow) |=> !overflow);

endmodule

bind wbq_writeback wbq_checker #(.DEPTH(DEPTH), .DEST_W(DEST_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_kind(push_kind),
    .commit   (commit),
    .discard  (discard),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .pend_cnt (pend_cnt),
    .overflow (overflow)
);

// File: tb/test_wbq_writeback.sv
module test_wbq_writeback;
    localparam int CLK_PERIOD = 100;
    localparam int NDEST = 16;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push = 1'b0;
    logic [1:0]  push_kind = '0;
    logic [3:0]  push_dest = '0;
    logic [1:0]  push_size = '0;
    logic [63:0] push_data = '0;
    logic [63:0] push_mask = '0;
    logic        commit = 1'b0;
    logic        discard = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic [4:0]  pend_cnt;
    logic        overflow;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    logic [63:0] m_reg [NDEST];
    int          m_qd  [DEPTH];
    logic [63:0] m_qdat[DEPTH];
    logic [63:0] m_qmsk[DEPTH];
    int          m_qsz [DEPTH];
    int          m_qn = 0;
    bit          m_ovf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbq_writeback i_wbq_writeback (
        .clk(clk), .rst(rst), .push(push), .push_kind(push_kind),
        .push_dest(push_dest), .push_size(push_size), .push_data(push_data),
        .push_mask(push_mask), .commit(commit), .discard(discard),
        .rd_idx(rd_idx), .rd_data(rd_data), .pend_cnt(pend_cnt), .overflow(overflow)
    );

    function automatic logic [63:0] keep_of(int s);
        case (s)
            0: return 64'hFF;
            1: return 64'hFFFF;
            2: return 64'hFFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    function automatic void m_add(int d, int s, logic [63:0] dat, logic [63:0] msk);
        m_qd[m_qn] = d; m_qsz[m_qn] = s;
        m_qdat[m_qn] = dat & keep_of(s); m_qmsk[m_qn] = msk & keep_of(s);
        m_qn++;
    endfunction

    function automatic void m_step(bit p, int k, int d, int s, logic [63:0] dat,
                                   logic [63:0] msk, bit c, bit x);
        int need;
        need = (k == 2) ? 2 : 1;
        if (x) m_qn = 0;
        else if (c) begin
            for (int i = 0; i < m_qn; i++)
                m_reg[m_qd[i]] = ((m_reg[m_qd[i]] & m_qmsk[i]) | m_qdat[i]) & keep_of(m_qsz[i]);
            m_qn = 0;
        end else if (p) begin
            if (m_qn + need > DEPTH) m_ovf = 1;
            else case (k)
                0: m_add(d, s, dat, 64'h0);
                1: m_add(d, s, dat, msk);
                2: begin
                    m_add(d, 1, {48'h0, dat[31:16]}, 64'h0);
                    m_add((d + 1) % NDEST, 1, {48'h0, dat[15:0]}, 64'h0);
                end
                default: m_add(d, 3, dat & 64'hFF_FFFF_FFFF, 64'h0);
            endcase
        end
    endfunction

    task automatic cyc(bit p, int k, int d, int s, logic [63:0] dat,
                       logic [63:0] msk, bit c, bit x);
        @(negedge clk);
        push = p; push_kind = 2'(k); push_dest = 4'(d); push_size = 2'(s);
        push_data = dat; push_mask = msk; commit = c; discard = x;
        @(posedge clk);
        m_step(p, k, d, s, dat, msk, c, x);
    endtask

    task automatic wr(int k, int d, int s, logic [63:0] dat, logic [63:0] msk);
        cyc(1, k, d, s, dat, msk, 0, 0);
    endtask

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_state(string req);
        @(negedge clk);
        push = 0; commit = 0; discard = 0;
        for (int i = 0; i < NDEST; i++) begin
            rd_idx = 4'(i);
            #1;
            chk(rd_data === m_reg[i], req, rd_data, m_reg[i]);
        end
        chk(int'(pend_cnt) == m_qn, req, 64'(pend_cnt), 64'(m_qn));
        chk(overflow === m_ovf, req, 64'(overflow), 64'(m_ovf));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        for (int i = 0; i < NDEST; i++) m_reg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check_state("R1");

        // R4 plain write, pending value hidden first (R2)
        wr(0, 3, 3, 64'h1122_3344_5566_7788, 64'hFFFF);
        check_state("R2");
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        check_state("R4");

        // R3 merge with 16-bit size, upper bits cleared
        wr(1, 3, 1, 64'hFFFF_0000_0000_00AA, 64'hFFFF_FFFF_FFFF_FF00);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        check_state("R3");

        // R5 later entry to same destination wins
        wr(0, 5, 2, 64'h1, 0);
        wr(0, 5, 2, 64'h2, 0);
        wr(1, 6, 0, 64'h0F, 64'h00);
        wr(1, 6, 0, 64'hA0, 64'h0F);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        check_state("R5");
        check_state("R6");

        // R8 pair write wrapping from the last destination
        wr(2, 15, 0, 64'hFFFF_0000_DEAD_BEEF, 0);
        check_state("R8");
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        check_state("R8");

        // R9 accumulator clip
        wr(3, 7, 0, '1, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        check_state("R9");

        // R7 discard, then commit+discard together
        wr(0, 7, 3, 64'h0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        check_state("R7");
        wr(0, 9, 3, 64'h55, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 1);
        check_state("R7");

        // R11 push alongside commit / discard
        wr(0, 10, 3, 64'h77, 0);
        cyc(1, 0, 11, 3, 64'h99, 0, 1, 0);
        check_state("R11");
        cyc(1, 0, 12, 3, 64'h99, 0, 0, 1);
        check_state("R11");

        // R10 overflow at depth, then pair with one free slot
        for (int i = 0; i < DEPTH; i++) wr(0, i, 1, 64'(i + 100), 0);
        check_state("R10");
        wr(0, 2, 3, 64'hBAD, 0);
        check_state("R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < DEPTH - 1; i++) wr(0, i, 0, 64'(i), 0);
        wr(2, 4, 0, 64'h1234_5678, 0);
        check_state("R10");
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        check_state("R10");

        // random rounds
        for (int r = 0; r < 40; r++) begin
            int n;
            n = $urandom_range(0, 18);
            for (int j = 0; j < n; j++)
                wr($urandom_range(0, 3), $urandom_range(0, NDEST - 1), $urandom_range(0, 3),
                   {$urandom, $urandom}, {$urandom, $urandom});
            check_state("R2");
            if ($urandom_range(0, 3) != 0) cyc(0, 0, 0, 0, 0, 0, 1, 0);
            else                           cyc(0, 0, 0, 0, 0, 0, 0, 1);
            check_state("R5");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule